// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers eight event pulses from a reader's transmit and receive datapath into one 8-bit status register and drives a single active-high interrupt line. Each event arrives as a one-cycle pulse. It sets a sticky flag at a fixed bit position. The interrupt line is the OR of every latched flag whose source is enabled. A host reads the status register to find out what happened. The read returns the flags and clears them in the same access.

Two protocol qualifiers decide whether some events are recorded at all. The CRC-error pulse is kept only while CRC checking is on. The parity-error pulse is kept only in Type A mode. Three sources can be masked in a small enable register: no-response, collision, and framing/end-of-frame error. The receive-start flag latches as soon as reception begins, but it does not raise the interrupt. The interrupt is raised only when a separate end-of-reception pulse arrives.

A second register holds the bit index reported with the latest collision. Reading it clears it. The normal host sequence reads the status register and then reads the next address (the mask) as a dummy before closing the transaction. That dummy read must not disturb anything.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the collision position reads 0, the mask reads 0x06 and `irq` is low.
- R2: A pulse on `evt_pulse[i]` sets status bit i, with this map: bit 7 transmit done, bit 6 receive start, bit 5 FIFO level, bit 4 CRC error, bit 3 parity error, bit 2 framing/EOF error, bit 1 collision, bit 0 no response. A transmit-done pulse alone reads back as 0x80.
- R3: A status read (`reg_rd` high with `reg_addr` equal to STAT_ADDR) returns the flags as they stood before that edge and clears all of them. A second read returns 0x00.
- R4: An event that arrives in the same cycle as a clearing status read is not part of that read's data. It is reported by the next status read.
- R5: Status bit 6 sets on the receive-start pulse without raising `irq`. A `rx_done` pulse raises `irq` on the next cycle, and the next status read clears it.
- R6: A pulse on bit 4 (CRC error) is latched only while `crc_chk_en` is 1. Otherwise it is dropped.
- R7: A pulse on bit 3 (parity error) is latched only while `type_a_mode` is 1. Otherwise it is dropped.
- R8: The mask register at STAT_ADDR+1 has three bits. Bit 2 enables framing, bit 1 enables collision and bit 0 enables no-response. The reset value is 0b110. Mask bits gate only `irq`, never the latching of a flag. Bits 7, 5, 4 and 3 always feed `irq`. Writing the mask changes `irq` from the next cycle on.
- R9: A collision pulse stores `col_index` in the position register at STAT_ADDR+2. The latest collision overwrites an earlier one. Reading the register returns the stored value and clears it to 0.
- R10: A read of the mask address returns the mask in bits 2:0 with zeros above, and changes neither the status flags nor the collision position.
- R11: `irq` rises in the cycle after the latching edge of an enabled event. It stays high until a status read, and it is low in the cycle after a status read that sees no new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 8 | One-cycle event pulses, at their status bit positions |
| rx_done | input | 1 | End-of-reception pulse |
| crc_chk_en | input | 1 | CRC checking on; qualifies bit 4 |
| type_a_mode | input | 1 | Type A protocol mode; qualifies bit 3 |
| col_index | input | COL_W | Bit index of the collision, valid with evt_pulse[1] |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench uses the default parameters: ADDR_W of 5, STAT_ADDR of 12 (mask at 13, collision position at 14) and COL_W of 8. With COL_W at 8, collision indices up to 0xFF can be checked, including the all-ones value. The default mask reset value lets the bench show a no-response flag that is latched while masked. Writing the mask afterwards raises `irq`. The bench also places an event in the same cycle as a clearing read, and it places a dummy mask read between status reads.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int STAT_W = 8;
    localparam int DATA_W = 8;
    localparam int MASK_W = 3;

    localparam int B_NORESP  = 0;
    localparam int B_COLL    = 1;
    localparam int B_FRAME   = 2;
    localparam int B_PARITY  = 3;
    localparam int B_CRC     = 4;
    localparam int B_FIFO    = 5;
    localparam int B_RXSTART = 6;
    localparam int B_TXDONE  = 7;

    typedef struct packed {
        logic stat_rd;
        logic mask_rd;
        logic col_rd;
        logic mask_wr;
    } acc_s;

    // Per-bit interrupt enable: receive-start never drives irq directly,
    // the three low sources follow the mask, the rest are always on.
    function automatic logic [STAT_W-1:0] src_enable(input logic [MASK_W-1:0] m);
        logic [STAT_W-1:0] e;
        e = '1;
        e[B_RXSTART] = 1'b0;
        e[MASK_W-1:0] = m;
        return e;
    endfunction

endpackage

// File: rtl/irq_access_decode.sv
module irq_access_decode
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int STAT_ADDR = 12
) (
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    output acc_s              acc
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(STAT_ADDR + 1);
    localparam logic [ADDR_W-1:0] A_COL  = ADDR_W'(STAT_ADDR + 2);

    always_comb begin
        acc.stat_rd = reg_rd && (reg_addr == A_STAT);
        acc.mask_rd = reg_rd && (reg_addr == A_MASK);
        acc.col_rd  = reg_rd && (reg_addr == A_COL);
        acc.mask_wr = reg_wr && (reg_addr == A_MASK);
    end
endmodule

// File: rtl/irq_event_gate.sv
module irq_event_gate
    import irq_stat_pkg::*;
(
    input  logic [STAT_W-1:0] evt_pulse,
    input  logic              crc_chk_en,
    input  logic              type_a_mode,
    output logic [STAT_W-1:0] evt_ok
);
    always_comb begin
        evt_ok           = evt_pulse;
        evt_ok[B_CRC]    = evt_pulse[B_CRC] && crc_chk_en;
        evt_ok[B_PARITY] = evt_pulse[B_PARITY] && type_a_mode;
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] evt_ok,
    input  logic              rx_done,
    input  logic              clr,
    output logic [STAT_W-1:0] status_q,
    output logic              rx_fin_q
);
    logic [STAT_W-1:0] keep;
    logic              fin_keep;

    always_comb begin
        keep     = clr ? '0 : status_q;
        fin_keep = clr ? 1'b0 : rx_fin_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            rx_fin_q <= 1'b0;
        end else begin
            status_q <= keep | evt_ok;
            rx_fin_q <= fin_keep | rx_done;
        end
    end
endmodule

// File: rtl/irq_col_capture.sv
module irq_col_capture #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic [COL_W-1:0] idx,
    input  logic             clr,
    output logic [COL_W-1:0] pos_q
);
    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (hit)
            pos_q <= idx;
        else if (clr)
            pos_q <= '0;
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_stat_pkg::*;
#(
    parameter int              ADDR_W    = 5,
    parameter int              STAT_ADDR = 12,
    parameter int              COL_W     = 8,
    parameter logic [2:0]      MASK_RST  = 3'b110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        evt_pulse,
    input  logic              rx_done,
    input  logic              crc_chk_en,
    input  logic              type_a_mode,
    input  logic [COL_W-1:0]  col_index,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    acc_s              acc;
    logic [STAT_W-1:0] evt_ok;
    logic [STAT_W-1:0] status_q;
    logic              rx_fin_q;
    logic [COL_W-1:0]  colpos_q;
    logic [MASK_W-1:0] mask_q;

    irq_access_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_dec (
        .reg_rd  (reg_rd),
        .reg_wr  (reg_wr),
        .reg_addr(reg_addr),
        .acc     (acc)
    );

    irq_event_gate u_gate (
        .evt_pulse  (evt_pulse),
        .crc_chk_en (crc_chk_en),
        .type_a_mode(type_a_mode),
        .evt_ok     (evt_ok)
    );

    irq_status_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .evt_ok  (evt_ok),
        .rx_done (rx_done),
        .clr     (acc.stat_rd),
        .status_q(status_q),
        .rx_fin_q(rx_fin_q)
    );

    irq_col_capture #(.COL_W(COL_W)) u_col (
        .clk  (clk),
        .rst  (rst),
        .hit  (evt_pulse[B_COLL]),
        .idx  (col_index),
        .clr  (acc.col_rd),
        .pos_q(colpos_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= MASK_RST;
        else if (acc.mask_wr)
            mask_q <= reg_wdata[MASK_W-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        if (acc.stat_rd)
            reg_rdata = status_q;
        else if (acc.mask_rd)
            reg_rdata = DATA_W'(mask_q);
        else if (acc.col_rd)
            reg_rdata = DATA_W'(colpos_q);
    end

    assign irq = (|(status_q & src_enable(mask_q))) | rx_fin_q;

endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
    import irq_stat_pkg::*;
#(
    parameter int COL_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        evt_pulse,
    input logic              rx_done,
    input logic              crc_chk_en,
    input logic              type_a_mode,
    input logic [COL_W-1:0]  col_index,
    input acc_s              acc,
    input logic [STAT_W-1:0] status_q,
    input logic [COL_W-1:0]  colpos_q,
    input logic              irq
);
    // R3
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.stat_rd && evt_pulse == 8'h00) |=> (status_q == 8'h00));

    // R4
    read_race_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.stat_rd && evt_pulse[B_TXDONE]) |=> status_q[B_TXDONE]);

    // R6
    crc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!crc_chk_en && !status_q[B_CRC]) |=> !status_q[B_CRC]);

    // R7
    parity_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!type_a_mode && !status_q[B_PARITY]) |=> !status_q[B_PARITY]);

    // R9
    col_capture_chk: assert property (@(posedge clk) disable iff (rst)
        evt_pulse[B_COLL] |=> (colpos_q == $past(col_index)));

    // R9
    col_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.col_rd && !evt_pulse[B_COLL]) |=> (colpos_q == '0));

    // R10
    mask_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.mask_rd && evt_pulse == 8'h00) |=> $stable(status_q));

    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(rx_done || (|evt_pulse) || acc.mask_wr));

    // R11
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.stat_rd && evt_pulse == 8'h00 && !rx_done) |=> !irq);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_pulse  (evt_pulse),
    .rx_done    (rx_done),
    .crc_chk_en (crc_chk_en),
    .type_a_mode(type_a_mode),
    .col_index  (col_index),
    .acc        (acc),
    .status_q   (status_q),
    .colpos_q   (colpos_q),
    .irq        (irq)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
    localparam int ADDR_W = 5;
    localparam int STAT   = 12;
    localparam int MASKA  = 13;
    localparam int COLA   = 14;
    localparam int COL_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        evt_pulse = '0;
    logic              rx_done = 1'b0;
    logic              crc_chk_en = 1'b0;
    logic              type_a_mode = 1'b0;
    logic [COL_W-1:0]  col_index = '0;
    logic              reg_rd = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_status_ctrl #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT), .COL_W(COL_W)) u_dut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .rx_done(rx_done),
        .crc_chk_en(crc_chk_en), .type_a_mode(type_a_mode), .col_index(col_index),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        reg_rd   = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic pulse(input logic [7:0] v, input logic [COL_W-1:0] ci);
        @(negedge clk);
        evt_pulse = v;
        col_index = ci;
        @(negedge clk);
        evt_pulse = '0;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq", irq, 0);
        rd(STAT, d);  check("R1 status", d, 8'h00);
        rd(MASKA, d); check("R1 mask", d, 8'h06);
        rd(COLA, d);  check("R1 colpos", d, 8'h00);
    endtask

    task automatic t_txdone();
        logic [7:0] d;
        pulse(8'h80, '0);
        check("R11 irq after tx done", irq, 1);
        rd(STAT, d);  check("R2 tx done alone", d, 8'h80);
        check("R11 irq after read", irq, 0);
        rd(STAT, d);  check("R3 second read", d, 8'h00);
    endtask

    task automatic t_each_bit();
        logic [7:0] d;
        crc_chk_en  = 1'b1;
        type_a_mode = 1'b1;
        wr(MASKA, 8'h07);
        for (int i = 0; i < 8; i++) begin
            if (i != 6) begin
                pulse(8'(1 << i), 8'h01);
                check($sformatf("R2 irq bit %0d", i), irq, 1);
                rd(STAT, d);
                check($sformatf("R2 status bit %0d", i), d, 1 << i);
            end
        end
        rd(COLA, d);
        wr(MASKA, 8'h06);
    endtask

    task automatic t_rx();
        logic [7:0] d;
        pulse(8'h40, '0);
        check("R5 no irq on rx start", irq, 0);
        @(negedge clk); rx_done = 1'b1;
        @(negedge clk); rx_done = 1'b0;
        #1 check("R5 irq at rx done", irq, 1);
        rd(STAT, d); check("R5 rx start flag", d, 8'h40);
        check("R5 irq cleared", irq, 0);
    endtask

    task automatic t_gates();
        logic [7:0] d;
        crc_chk_en  = 1'b0;
        type_a_mode = 1'b0;
        pulse(8'h18, '0);
        check("R6 R7 dropped irq", irq, 0);
        rd(STAT, d); check("R6 R7 dropped", d, 8'h00);
        crc_chk_en = 1'b1;
        pulse(8'h18, '0);
        rd(STAT, d); check("R6 crc only", d, 8'h10);
        crc_chk_en  = 1'b0;
        type_a_mode = 1'b1;
        pulse(8'h18, '0);
        rd(STAT, d); check("R7 parity only", d, 8'h08);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        pulse(8'h01, '0);
        check("R8 noresp masked at reset", irq, 0);
        wr(MASKA, 8'hF9);
        check("R8 irq after unmask", irq, 1);
        rd(MASKA, d); check("R10 mask read upper zero", d, 8'h01);
        rd(STAT, d); check("R8 noresp latched", d, 8'h01);
        wr(MASKA, 8'h00);
        pulse(8'h07, 8'h03);
        check("R8 all masked", irq, 0);
        rd(STAT, d); check("R8 latched while masked", d, 8'h07);
        rd(COLA, d);
        wr(MASKA, 8'h06);
    endtask

    task automatic t_race();
        logic [7:0] d;
        @(negedge clk);
        evt_pulse = 8'h20;
        reg_addr  = ADDR_W'(STAT);
        reg_rd    = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        evt_pulse = '0;
        reg_rd    = 1'b0;
        #1;
        check("R4 race read data", d, 8'h00);
        check("R4 irq kept", irq, 1);
        rd(STAT, d); check("R4 kept for next read", d, 8'h20);
    endtask

    task automatic t_col();
        logic [7:0] d;
        pulse(8'h02, 8'h2A);
        rd(COLA, d); check("R9 colpos", d, 8'h2A);
        rd(COLA, d); check("R9 colpos cleared", d, 8'h00);
        rd(STAT, d); check("R9 collision flag", d, 8'h02);
        pulse(8'h02, 8'h05);
        pulse(8'h02, 8'hFF);
        rd(COLA, d); check("R9 last wins", d, 8'hFF);
        rd(STAT, d);
        pulse(8'h82, 8'h11);
        rd(STAT, d);  check("R10 status before dummy", d, 8'h82);
        pulse(8'h80, 8'h00);
        rd(MASKA, d); check("R10 dummy mask read", d, 8'h06);
        rd(STAT, d);  check("R10 status survives dummy", d, 8'h80);
        rd(COLA, d);  check("R10 colpos survives dummy", d, 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_txdone();
        t_each_bit();
        t_rx();
        t_gates();
        t_mask();
        t_race();
        t_col();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule